// File: doc/BRIEF.md
# Four-Level Priority Interrupt Acknowledger

This block sits beside a processor's microsequencer and resolves four level-sensitive interrupt request lines. The lines are numbered 0 to 3, and a lower number means a higher priority. The block looks at the requests once per processor cycle, in the first phase. It does this only while it is idle and no other bus transaction holds the bus. When an unmasked request is pending, the block signals the sequencer that an acknowledge sequence replaces normal execution. It then runs a bus cycle of the address-read/address-write kind.

In that bus cycle the sync strobe rises in phase 2. The acknowledge strobe rises with it. The bus carries a 4-bit level code, and that code doubles as the new interrupt mask. The addressed unit answers on the reply line, which the block samples in phase 3. A low reply repeats the phase-3 wait while sync stays high. After a high reply, sync and acknowledge drop together at the next phase 2, and the code is loaded into the mask register. A one-bit service-exit input clears the mask.

Top module: `intack_ctrl`

## Requirements
- R1: When several unmasked requests are pending, the lowest-numbered level is acknowledged.
- R2: While sync is high, the bus driver is enabled and bus bits [3:0] carry the level code, with bit i set for every i greater than or equal to the acknowledged level (level 0 gives 4'b1111, 1 gives 4'b1110, 2 gives 4'b1100, 3 gives 4'b1000). All higher bus bits are zero.
- R3: The acknowledge output is high exactly when sync is high; it rises and falls on the same edges as sync.
- R4: Sync rises on the phase-2 edge following the decision. A low reply at a phase-3 edge keeps sync high for another cycle. After a high reply at phase 3, sync falls on the next phase-2 edge.
- R5: Requests are sampled only on a phase-1 edge, only when the block is idle, and only when bus_busy is low.
- R6: A level whose mask bit is set is ignored. On completion, the mask register takes the level code.
- R7: A pulse on svc_exit clears the mask register.
- R8: Reset clears the mask and the sync, acknowledge, bus-enable, active and done outputs, and returns the block to idle.
- R9: svc_active is high from the decision until sync falls. svc_done is a one-cycle pulse on the edge where sync falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_en | input | 4 | One-hot phase enable, bit k = phase k+1 |
| irq_req | input | 4 | Level-sensitive interrupt requests, bit 0 highest priority |
| bus_busy | input | 1 | Another bus transaction is in progress |
| svc_exit | input | 1 | Service exit, clears the mask |
| reply_i | input | 1 | Reply from the addressed unit |
| svc_active | output | 1 | Acknowledge sequence in progress; sequencer holds normal execution |
| svc_done | output | 1 | One-cycle pulse when the sequence completes |
| sync_o | output | 1 | Bus transaction sync strobe |
| iack_o | output | 1 | Interrupt acknowledge strobe |
| dal_o | output | 16 | Data/address bus value |
| dal_oe | output | 1 | Bus driver enable |

## Verification
The bench presents several requests at once and expects the lowest number to win. A picker that scanned from the wrong end would place the wrong code on the bus. It withholds the reply for several phase-3 slots. A design that ignored the reply would drop sync early, and one that tracked acknowledge separately from sync would break their alignment. After a completed acknowledge it raises a lower-priority request and expects silence, then a higher-priority one and expects an acknowledge. A mask loaded wrongly, or never loaded, shows up in one of those two results. It also holds bus_busy high during a pending request and resets in the middle of a transaction; a block that sampled at the wrong time or kept stale state would raise sync.

// File: rtl/intack_pkg.sv
package intack_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ADDR   = 2'd1,
        ST_WREPLY = 2'd2,
        ST_HOLD   = 2'd3
    } ack_st_e;
endpackage

// File: rtl/intack_prio.sv
module intack_prio #(
    parameter int NUM_LVL = 4,
    localparam int LW = $clog2(NUM_LVL)
) (
    input  logic [NUM_LVL-1:0] req,
    input  logic [NUM_LVL-1:0] mask,
    output logic               any,
    output logic [NUM_LVL-1:0] grant,
    output logic [LW-1:0]      lvl
);
    logic [NUM_LVL-1:0] pend;

    always_comb begin
        pend  = req & ~mask;
        any   = |pend;
        grant = '0;
        lvl   = '0;
        // scan downward so the lowest pending index is the last write
        for (int i = NUM_LVL - 1; i >= 0; i--) begin
            if (pend[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                lvl      = LW'(i);
            end
        end
    end

    // R1: at most one level granted, and only a pending one
    always_comb begin
        p_grant_onehot_r1: assert ($onehot0(grant));
        p_grant_pending_r1: assert ((grant & ~pend) == '0);
    end
endmodule

// File: rtl/intack_mask.sv
module intack_mask #(
    parameter int NUM_LVL = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld,
    input  logic [NUM_LVL-1:0] ld_val,
    input  logic               clr,
    output logic [NUM_LVL-1:0] mask
);
    logic [NUM_LVL-1:0] mask_d, mask_q;

    always_comb begin
        mask_d = mask_q;
        if (clr)
            mask_d = '0;
        if (ld)
            mask_d = ld_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else
            mask_q <= mask_d;
    end

    assign mask = mask_q;

    p_exit_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !ld) |=> (mask == '0));
    p_load_takes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (mask == $past(ld_val)));
endmodule

// File: rtl/intack_ctrl.sv
module intack_ctrl
    import intack_pkg::*;
#(
    parameter int NUM_LVL = 4,
    parameter int DAL_W   = 16,
    localparam int LW     = $clog2(NUM_LVL)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [3:0]         phase_en,
    input  logic [NUM_LVL-1:0] irq_req,
    input  logic               bus_busy,
    input  logic               svc_exit,
    input  logic               reply_i,
    output logic               svc_active,
    output logic               svc_done,
    output logic               sync_o,
    output logic               iack_o,
    output logic [DAL_W-1:0]   dal_o,
    output logic               dal_oe
);
    typedef struct packed {
        ack_st_e            st;
        logic               sync;
        logic               iack;
        logic               oe;
        logic [NUM_LVL-1:0] code;
        logic               done;
    } ctrl_t;

    ctrl_t r_d, r_q;

    logic               any_pend;
    logic [NUM_LVL-1:0] grant;
    logic [LW-1:0]      win_lvl;
    logic [NUM_LVL-1:0] mask;
    logic               mask_ld;
    logic [NUM_LVL-1:0] lvl_code;

    intack_prio #(.NUM_LVL(NUM_LVL)) u_prio (
        .req   (irq_req),
        .mask  (mask),
        .any   (any_pend),
        .grant (grant),
        .lvl   (win_lvl)
    );

    intack_mask #(.NUM_LVL(NUM_LVL)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (mask_ld),
        .ld_val (r_q.code),
        .clr    (svc_exit),
        .mask   (mask)
    );

    // code masks the winning level and every lower-priority level
    always_comb begin
        for (int i = 0; i < NUM_LVL; i++)
            lvl_code[i] = (i >= int'(win_lvl));
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        mask_ld  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (phase_en[0] && !bus_busy && any_pend) begin
                    r_d.st   = ST_ADDR;
                    r_d.code = lvl_code;
                end
            end
            ST_ADDR: begin
                if (phase_en[1]) begin
                    r_d.sync = 1'b1;
                    r_d.iack = 1'b1;
                    r_d.oe   = 1'b1;
                    r_d.st   = ST_WREPLY;
                end
            end
            ST_WREPLY: begin
                if (phase_en[2] && reply_i)
                    r_d.st = ST_HOLD;
            end
            ST_HOLD: begin
                if (phase_en[1]) begin
                    r_d.sync = 1'b0;
                    r_d.iack = 1'b0;
                    r_d.oe   = 1'b0;
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                    mask_ld  = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.sync <= 1'b0;
            r_q.iack <= 1'b0;
            r_q.oe   <= 1'b0;
            r_q.code <= '0;
            r_q.done <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        dal_o = '0;
        if (r_q.oe)
            dal_o[NUM_LVL-1:0] = r_q.code;
    end

    assign sync_o     = r_q.sync;
    assign iack_o     = r_q.iack;
    assign dal_oe     = r_q.oe;
    assign svc_done   = r_q.done;
    assign svc_active = (r_q.st != ST_IDLE);

    p_sync_rise_ph2_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_o) |-> $past(phase_en[1]));
    p_sync_fall_ph2_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_o) |-> $past(phase_en[1]));
    p_retry_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_o && phase_en[2] && !reply_i) |=> sync_o);
    p_iack_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
        iack_o == sync_o);
    p_drive_while_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |-> dal_oe);
    p_pick_in_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(svc_active) |-> ($past(phase_en[0]) && !$past(bus_busy)));
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        svc_done |=> !svc_done);
endmodule

// File: tb/intack_ctrl_bench.sv
module intack_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  phase_en;
    logic [3:0]  irq_req;
    logic        bus_busy;
    logic        svc_exit;
    logic        reply_i;
    logic        svc_active, svc_done, sync_o, iack_o, dal_oe;
    logic [15:0] dal_o;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    always #4 clk = ~clk;

    initial phase_en = 4'b0001;
    always @(negedge clk) begin
        phase_en <= {phase_en[2:0], phase_en[3]};
        cyc      <= cyc + 1;
    end

    intack_ctrl u_intack_ctrl (
        .clk(clk), .rst_n(rst_n), .phase_en(phase_en), .irq_req(irq_req),
        .bus_busy(bus_busy), .svc_exit(svc_exit), .reply_i(reply_i),
        .svc_active(svc_active), .svc_done(svc_done), .sync_o(sync_o),
        .iack_o(iack_o), .dal_o(dal_o), .dal_oe(dal_oe)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse_exit();
        svc_exit = 1'b1;
        @(negedge clk);
        svc_exit = 1'b0;
        @(negedge clk);
    endtask

    task automatic expect_quiet(input int ncyc, input string req);
        bit quiet = 1'b1;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            if (sync_o || svc_active) quiet = 1'b0;
        end
        chk(quiet, req, "no acknowledge while blocked", {31'd0, ~quiet}, 0);
    endtask

    // one full acknowledge, with retry_slots phase-3 slots answered low
    task automatic run_ack(input logic [3:0] exp_code, input int retry_slots,
                           input string req);
        bit seen = 1'b0;
        bit fell = 1'b0;
        bit aligned = 1'b1;
        for (int i = 0; i < 60 && !seen; i++) begin
            @(negedge clk);
            if (sync_o) seen = 1'b1;
        end
        chk(seen, req, "sync raised", {31'd0, seen}, 1);
        if (!seen) return;
        chk(phase_en == 4'b0010, "R4", "sync rose on phase 2", phase_en, 4'b0010);
        chk(iack_o, "R3", "iack rises with sync", iack_o, 1);
        chk(dal_oe && dal_o == {12'd0, exp_code}, req, "level code on bus (R2)",
            dal_o, {12'd0, exp_code});
        chk(svc_active, "R9", "active during acknowledge", svc_active, 1);
        irq_req = 4'b0000;
        for (int i = 0; i < retry_slots * 4; i++) begin
            @(negedge clk);
            if (!(sync_o && iack_o)) aligned = 1'b0;
        end
        chk(aligned, "R4", "sync and iack hold through retries", {31'd0, aligned}, 1);
        reply_i = 1'b1;
        for (int i = 0; i < 20 && !fell; i++) begin
            @(negedge clk);
            if (iack_o != sync_o) aligned = 1'b0;
            if (!sync_o) begin
                fell = 1'b1;
                chk(phase_en == 4'b0010, "R4", "sync fell on phase 2", phase_en, 4'b0010);
                chk(svc_done && !svc_active, "R9", "done pulse as sync drops",
                    {svc_done, svc_active}, 2'b10);
                chk(!dal_oe && !iack_o, "R3", "iack and bus released with sync",
                    {dal_oe, iack_o}, 0);
            end
        end
        chk(fell && aligned, "R3", "iack equals sync until end",
            {fell, aligned}, 2'b11);
        reply_i = 1'b0;
        @(negedge clk);
        chk(!svc_done, "R9", "done lasts one cycle", svc_done, 0);
    endtask

    task automatic t_reset();
        do_reset();
        chk({sync_o, iack_o, dal_oe, svc_active, svc_done} == 0, "R8",
            "outputs clear after reset", {sync_o, iack_o, dal_oe, svc_active, svc_done}, 0);
        chk(dal_o == 0, "R8", "bus zero after reset", dal_o, 0);
    endtask

    task automatic t_priority();
        irq_req = 4'b1010;            // R1: levels 1 and 3, level 1 wins
        run_ack(4'b1110, 0, "R1");
        pulse_exit();
        irq_req = 4'b1111;            // R1: all pending, level 0 wins
        run_ack(4'b1111, 1, "R1");
        pulse_exit();
    endtask

    task automatic t_retry();
        irq_req = 4'b0100;            // R4: several low replies
        run_ack(4'b1100, 3, "R2");
    endtask

    task automatic t_mask();
        irq_req = 4'b1000;            // R6: mask now 4'b1100, level 3 ignored
        expect_quiet(40, "R6");
        irq_req = 4'b1001;            // R6: level 0 not masked
        run_ack(4'b1111, 0, "R6");
        irq_req = 4'b0010;            // R6: mask now all ones
        expect_quiet(40, "R6");
        irq_req = 4'b0000;
        pulse_exit();
        irq_req = 4'b1000;            // R7: exit cleared mask
        run_ack(4'b1000, 0, "R7");
        pulse_exit();
    endtask

    task automatic t_busy();
        bus_busy = 1'b1;
        irq_req  = 4'b0010;           // R5: held off by busy bus
        expect_quiet(40, "R5");
        bus_busy = 1'b0;
        run_ack(4'b1110, 0, "R5");
        pulse_exit();
    endtask

    task automatic t_reset_mid();
        bit seen = 1'b0;
        irq_req = 4'b0001;
        for (int i = 0; i < 60 && !seen; i++) begin
            @(negedge clk);
            if (sync_o) seen = 1'b1;
        end
        chk(seen, "R8", "sync before mid reset", {31'd0, seen}, 1);
        irq_req = 4'b0000;
        do_reset();
        chk({sync_o, iack_o, dal_oe, svc_active} == 0, "R8",
            "mid-transaction reset clears", {sync_o, iack_o, dal_oe, svc_active}, 0);
        irq_req = 4'b1000;            // R8: mask cleared by reset
        run_ack(4'b1000, 0, "R8");
        pulse_exit();
    endtask

    initial begin
        irq_req  = 4'b0000;
        bus_busy = 1'b0;
        svc_exit = 1'b0;
        reply_i  = 1'b0;
        t_reset();
        t_priority();
        t_retry();
        t_mask();
        t_busy();
        t_reset_mid();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        wait (cyc >= 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule